// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table kept in memory. A requester hands over a virtual address through a valid/ready handshake, together with the physical location of the top-level table. The walker reads one entry from the top-level table. If that entry is marked present, it reads one entry from the second-level table that the first entry points to. It then returns the physical address, or a fault that names the level where the walk stopped.

Pages are 4 KiB. The 12 low address bits go straight through to the physical address. The 20 bits above them split into two 10-bit indices: the upper index selects the top-level entry and the lower index selects the second-level entry. Every entry is 4 bytes wide. In an entry, bits [31:12] hold a 4 KiB-aligned frame or table address and bit 0 is the present flag. Table reads leave through a single memory port that has a request handshake and a one-beat response.

Only one walk runs at a time. The result stays on the outputs until the requester accepts it.

Top module: `ptw_top`

## Requirements
- R1: After reset, `req_ready` is 1, and `resp_valid` and `mem_req_valid` are 0.
- R2: The first table read of a walk goes to address {root[31:12], va[31:22], 2'b00}. Here root is `root_addr` sampled when the request is accepted. Bits [11:0] of `root_addr` have no effect.
- R3: The second table read goes to address {E1[31:12], va[21:12], 2'b00}, where E1 is the first entry returned. This read is issued only after the first response arrives and only when E1[0] is 1.
- R4: At most one table read is outstanding at a time. No new read is issued before the previous response arrives. While a read request waits for `mem_req_ready`, the request and its address stay unchanged.
- R5: When both entries have bit 0 set, the walker returns `resp_fault`=0 and `resp_paddr` = {E2[31:12], va[11:0]}, where E2 is the second entry.
- R6: When E1[0] is 0, the walker returns `resp_fault`=1 with `resp_level`=0 and issues no second read.
- R7: When E1[0] is 1 and E2[0] is 0, the walker returns `resp_fault`=1 with `resp_level`=1.
- R8: Entry bits [11:1] have no effect on any address the walker issues or returns.
- R9: `req_ready` is 0 from the cycle after a request is accepted until the cycle after its response handshake completes.
- R10: While `resp_valid` is 1 and `resp_ready` is 0, every response output holds its value.
- R11: `resp_vaddr` equals the virtual address of the accepted request. This applies to both translations and faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker is idle and can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| root_addr | input | 32 | Physical address of the top-level table (bits [11:0] ignored) |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the table entry to read |
| mem_rsp_valid | input | 1 | Read data valid (one cycle per read) |
| mem_rsp_data | input | 32 | Table entry returned by memory |
| resp_valid | output | 1 | Translation result or fault valid |
| resp_ready | input | 1 | Requester accepts the result |
| resp_fault | output | 1 | 1 when the walk met an entry whose present bit is clear |
| resp_level | output | 1 | Fault level: 0 for the top-level table, 1 for the second level |
| resp_paddr | output | 32 | Translated physical address (0 on a fault) |
| resp_vaddr | output | 32 | Virtual address that this result belongs to |

## Verification
The bench aims at walks that stop at each level, and it checks that a top-level fault issues no second read. A walker that skipped the present check would return a translation built from a stale frame, and one that ignored the level would report the wrong level. The table entries carry random values in bits [11:1], and the root register carries random values in bits [11:0]. A design that folded those bits into an address would issue a wrong read address, which the bench compares against a model walk. Random stalls on the memory request, random response latency and random back-pressure on the result test whether the walker holds its request and result steady. They also test whether it overlaps reads and whether it accepts a new request too early.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_RESP
  } walk_state_e;

  localparam logic LVL_OUTER = 1'b0;
  localparam logic LVL_INNER = 1'b1;
endpackage

// File: rtl/ptw_index_pick.sv
// Selects one table index field out of a virtual address.
module ptw_index_pick #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10,
  parameter int LEVEL = 0   // 0 = field just above the offset
) (
  input  logic [VA_W-1:0]  vaddr_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int LSB = OFF_W + LEVEL * IDX_W;

  assign idx_o = vaddr_i[LSB +: IDX_W];

  wire unused_va = ^vaddr_i;
endmodule

// File: rtl/ptw_entry_addr.sv
// Byte address of an entry: aligned table base plus index scaled by entry size.
module ptw_entry_addr #(
  parameter int PA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int PTE_LG = 2
) (
  input  logic [PA_W-OFF_W-1:0] frame_i,
  input  logic [IDX_W-1:0]      idx_i,
  output logic [PA_W-1:0]       addr_o
);
  assign addr_o = {frame_i, {OFF_W{1'b0}}} + (PA_W'(idx_i) << PTE_LG);
endmodule

// File: rtl/ptw_pte_decode.sv
// Splits a table entry into its present flag and frame field.
module ptw_pte_decode #(
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic [PA_W-1:0]       pte_i,
  output logic                  present_o,
  output logic [PA_W-OFF_W-1:0] frame_o
);
  assign present_o = pte_i[0];
  assign frame_o   = pte_i[PA_W-1:OFF_W];

  wire unused_flags = ^pte_i[OFF_W-1:1];
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int PTE_LG = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [PA_W-1:0] root_addr,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [PA_W-1:0] mem_rsp_data,
  output logic            resp_valid,
  input  logic            resp_ready,
  output logic            resp_fault,
  output logic            resp_level,
  output logic [PA_W-1:0] resp_paddr,
  output logic [VA_W-1:0] resp_vaddr
);
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int NLEVELS = 2;

  walk_state_e            state_q;
  logic                   lvl_q;
  logic [VA_W-1:0]        vaddr_q;

  // Index fields: level 1 comes from the live request, level 0 from the latched address
  logic [IDX_W-1:0] idx_outer, idx_inner;
  logic [VA_W-1:0]  idx_src [NLEVELS];
  logic [IDX_W-1:0] idx_out [NLEVELS];
  assign idx_src[0] = vaddr_q;
  assign idx_src[1] = req_vaddr;

  for (genvar g = 0; g < NLEVELS; g++) begin : g_idx
    ptw_index_pick #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVEL(g)) u_pick (
      .vaddr_i(idx_src[g]),
      .idx_o  (idx_out[g])
    );
  end
  assign idx_inner = idx_out[0];
  assign idx_outer = idx_out[1];

  // Entry decode of the returned word
  logic               pte_present;
  logic [FRAME_W-1:0] pte_frame;
  ptw_pte_decode #(.PA_W(PA_W), .OFF_W(OFF_W)) u_dec (
    .pte_i    (mem_rsp_data),
    .present_o(pte_present),
    .frame_o  (pte_frame)
  );

  // Entry addresses for both levels
  logic [PA_W-1:0] outer_addr, inner_addr;
  ptw_entry_addr #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PTE_LG(PTE_LG)) u_oaddr (
    .frame_i(root_addr[PA_W-1:OFF_W]),
    .idx_i  (idx_outer),
    .addr_o (outer_addr)
  );
  ptw_entry_addr #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PTE_LG(PTE_LG)) u_iaddr (
    .frame_i(pte_frame),
    .idx_i  (idx_inner),
    .addr_o (inner_addr)
  );

  wire unused_root = ^root_addr[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      lvl_q         <= LVL_OUTER;
      vaddr_q       <= '0;
      req_ready     <= 1'b1;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      resp_valid    <= 1'b0;
      resp_fault    <= 1'b0;
      resp_level    <= 1'b0;
      resp_paddr    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            vaddr_q       <= req_vaddr;
            lvl_q         <= LVL_OUTER;
            req_ready     <= 1'b0;
            mem_req_addr  <= outer_addr;
            mem_req_valid <= 1'b1;
            state_q       <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state_q       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (!pte_present) begin
              resp_valid <= 1'b1;
              resp_fault <= 1'b1;
              resp_level <= lvl_q;
              resp_paddr <= '0;
              state_q    <= ST_RESP;
            end else if (lvl_q == LVL_OUTER) begin
              lvl_q         <= LVL_INNER;
              mem_req_addr  <= inner_addr;
              mem_req_valid <= 1'b1;
              state_q       <= ST_REQ;
            end else begin
              resp_valid <= 1'b1;
              resp_fault <= 1'b0;
              resp_level <= lvl_q;
              resp_paddr <= {pte_frame, vaddr_q[OFF_W-1:0]};
              state_q    <= ST_RESP;
            end
          end
        end
        ST_RESP: begin
          if (resp_ready) begin
            resp_valid <= 1'b0;
            req_ready  <= 1'b1;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign resp_vaddr = vaddr_q;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            resp_valid,
  input logic            resp_ready,
  input logic            resp_fault,
  input logic            resp_level,
  input logic [PA_W-1:0] resp_paddr,
  input logic [VA_W-1:0] resp_vaddr
);
  logic outstanding;
  always_ff @(posedge clk) begin
    if (rst) outstanding <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
    else if (mem_rsp_valid) outstanding <= 1'b0;
  end

  // R4: no new read while one is in flight
  a_r4_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    outstanding |-> !mem_req_valid);

  // R4: stalled read request holds
  a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R9: busy right after acceptance
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);

  // R9: not ready while a result is pending
  a_r9_busy_while_resp: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !req_ready);

  // R10: result holds under back-pressure
  a_r10_resp_hold: assert property (@(posedge clk) disable iff (rst)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_fault) && $stable(resp_level)
      && $stable(resp_paddr) && $stable(resp_vaddr));
endmodule

bind ptw_top ptw_checker #(.VA_W(VA_W), .PA_W(PA_W)) u_ptw_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .resp_valid(resp_valid), .resp_ready(resp_ready),
  .resp_fault(resp_fault), .resp_level(resp_level), .resp_paddr(resp_paddr),
  .resp_vaddr(resp_vaddr)
);

// File: tb/tb_ptw_top.sv
`timescale 1ns/1ps
module tb_ptw_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr, root_addr;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        resp_valid, resp_ready, resp_fault, resp_level;
  logic [31:0] resp_paddr, resp_vaddr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ptw_top dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .root_addr(root_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_fault(resp_fault),
    .resp_level(resp_level), .resp_paddr(resp_paddr), .resp_vaddr(resp_vaddr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory image: hashed word per address, present roughly 3 times in 4
  function automatic logic [31:0] pte(input logic [31:0] a);
    logic [31:0] h;
    h = a ^ (a >> 13);
    h = h * 32'h9E3779B1;
    h = h ^ (h >> 16);
    return {h[31:1], (h[7:6] != 2'b00)};
  endfunction

  function automatic logic [31:0] outer_addr(input logic [31:0] va, input logic [31:0] root);
    return {root[31:12], va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] inner_addr(input logic [31:0] va, input logic [31:0] e1);
    return {e1[31:12], va[21:12], 2'b00};
  endfunction

  // 0 = outer fault, 1 = inner fault, 2 = translation
  function automatic int walk_kind(input logic [31:0] va, input logic [31:0] root);
    logic [31:0] e1, e2;
    e1 = pte(outer_addr(va, root));
    if (!e1[0]) return 0;
    e2 = pte(inner_addr(va, e1));
    if (!e2[0]) return 1;
    return 2;
  endfunction

  // Memory responder
  logic [31:0] seen_addr [2];
  int          seen_cnt;
  bit          mbusy;
  int          mcnt;
  logic [31:0] maddr;
  bit          stall_en = 1'b1;

  always @(negedge clk) begin
    cycles++;
    mem_rsp_valid = 1'b0;
    if (!rst) begin
      if (mbusy) begin
        if (mem_req_valid) check(1'b0, "R4 request while read outstanding", 32'd1, 32'd0);
        mem_req_ready = 1'b0;
        if (mcnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pte(maddr);
          mbusy = 1'b0;
        end else mcnt--;
      end else begin
        mem_req_ready = stall_en ? (($urandom % 4) != 0) : 1'b1;
        if (mem_req_valid && mem_req_ready) begin
          if (seen_cnt < 2) seen_addr[seen_cnt] = mem_req_addr;
          seen_cnt++;
          maddr = mem_req_addr;
          mbusy = 1'b1;
          mcnt  = stall_en ? int'($urandom % 3) : 0;
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] root, input bit bp);
    logic [31:0] e1, e2, exp_paddr;
    bit exp_fault, exp_level, got, done;
    int exp_reads, k;
    logic [31:0] h_paddr, h_vaddr;
    logic h_fault, h_level;
    e1 = pte(outer_addr(va, root));
    e2 = pte(inner_addr(va, e1));
    exp_reads = e1[0] ? 2 : 1;
    exp_fault = !(e1[0] && e2[0]);
    exp_level = e1[0];
    exp_paddr = exp_fault ? 32'd0 : {e2[31:12], va[11:0]};

    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready when idle", {31'd0, req_ready}, 32'd1);
    seen_cnt  = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    root_addr = root;
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = $urandom;
    root_addr = $urandom;
    got = 1'b0; done = 1'b0; k = 0;
    h_paddr = '0; h_vaddr = '0; h_fault = 1'b0; h_level = 1'b0;
    while (!done && k < 200) begin
      check(req_ready == 1'b0, "R9 busy during walk", {31'd0, req_ready}, 32'd0);
      if (resp_valid) begin
        if (!got) begin
          got = 1'b1;
          h_paddr = resp_paddr; h_vaddr = resp_vaddr; h_fault = resp_fault; h_level = resp_level;
          check(seen_cnt == exp_reads, exp_fault && !exp_level ? "R6 read count" : "R3 read count",
                seen_cnt, exp_reads);
          check(seen_addr[0] == outer_addr(va, root), "R2 outer address", seen_addr[0], outer_addr(va, root));
          if (exp_reads == 2)
            check(seen_addr[1] == inner_addr(va, e1), "R3/R8 inner address", seen_addr[1], inner_addr(va, e1));
          check(resp_fault == exp_fault, "R5/R6/R7 fault flag", {31'd0, resp_fault}, {31'd0, exp_fault});
          if (exp_fault)
            check(resp_level == exp_level, exp_level ? "R7 level" : "R6 level", {31'd0, resp_level}, {31'd0, exp_level});
          else
            check(resp_paddr == exp_paddr, "R5/R8 physical address", resp_paddr, exp_paddr);
          check(resp_vaddr == va, "R11 vaddr", resp_vaddr, va);
        end else begin
          check(resp_paddr == h_paddr && resp_vaddr == h_vaddr && resp_fault == h_fault
                && resp_level == h_level, "R10 held response", resp_paddr, h_paddr);
        end
        resp_ready = bp ? (($urandom % 3) == 0) : 1'b1;
        if (resp_ready) done = 1'b1;
      end else resp_ready = 1'b0;
      @(negedge clk);
      k++;
    end
    resp_ready = 1'b0;
    check(done, "R5 response delivered", {31'd0, done}, 32'd1);
    check(req_ready == 1'b1 && resp_valid == 1'b0, "R9 ready after handshake", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic directed(input int kind);
    logic [31:0] va, root;
    int n;
    n = 0;
    do begin
      va = $urandom; root = $urandom; n++;
    end while (walk_kind(va, root) != kind && n < 1000);
    walk(va, root, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; root_addr = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; resp_ready = 1'b0;
    seen_cnt = 0; mbusy = 1'b0; mcnt = 0; maddr = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 req_ready after reset", {31'd0, req_ready}, 32'd1);
    check(resp_valid == 1'b0, "R1 resp_valid after reset", {31'd0, resp_valid}, 32'd0);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid after reset", {31'd0, mem_req_valid}, 32'd0);

    // Directed: outer fault (R6), inner fault (R7), translation (R5)
    directed(0);
    directed(1);
    directed(2);
    // Extremes of the index fields with a root carrying low junk bits (R2, R8)
    walk(32'hFFFF_FFFF, 32'h0012_3FFF, 1'b0);
    walk(32'h0000_0000, 32'hFFFF_F001, 1'b0);
    // No stalls, no back-pressure
    stall_en = 1'b0;
    for (int i = 0; i < 20; i++) walk($urandom, $urandom, 1'b0);
    stall_en = 1'b1;
    // Random with stalls and back-pressure
    for (int i = 0; i < 150; i++) walk($urandom, $urandom, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule